// File: doc/BRIEF.md
# MDIO management master

This block drives the two-wire PHY management interface of an Ethernet port: a serial clock (MDC) and a bidirectional data line, split here into an output value, an output enable and an input sample. Software reaches it through six small registers on a simple write port with a combinational read-back mux. A write frame is launched by storing a value into the write-data register. A read frame is launched by setting bit 0 of the command register, and software clears that bit again once the result has been collected.

Each frame carries 64 bits, most significant bit first: 32 preamble ones, start `01`, opcode (`10` read, `01` write), 5-bit PHY address, 5-bit register number, turnaround, and 16 data bits. MDC is divided from the system clock by a divisor that an encoded select field chooses. The busy indicator stays high from the first cycle of a frame to its last. A soft reset bit in the configuration register aborts a frame and holds the engine idle.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads 0, MDC is low and the data output enable is low.
- R2: The address register (offset 2) keeps the register number in bits 4:0 and the PHY address in bits 12:8. All other bits read 0.
- R3: A write to the write-data register (offset 3) while idle starts a write frame. The line carries 32 ones, `01`, `01`, PHY address, register number, `10`, then the 16 data bits, MSB first. The output enable is high for all 64 bits.
- R4: Writing 1 to command bit 0 (offset 1) while the stored bit is 0 and the block is idle starts a read frame with opcode `10`. The output enable is high for the first 46 bits and low for the turnaround and the 16 data bits.
- R5: During a read, the input is sampled at the MDC rising edges of the last 16 bits. From the cycle busy falls, the sampled value reads from the read-data register (offset 4) bits 15:0.
- R6: Indicator bit 0 (offset 5) rises in the cycle after the launching write. It stays high for exactly 64 MDC periods.
- R7: Configuration bits 4:2 (offset 0) select the divisor: 0..7 give 4, 4, 6, 8, 10, 14, 20, 28. The code 0x1C therefore divides by 28. MDC stays high and low for half the divisor each.
- R8: Configuration bit 15 aborts any frame. Within two cycles busy, MDC and the output enable are low. Launch writes are ignored while the bit is set.
- R9: A write to the write-data or command register while busy, including one that lands on the frame's final edge, alters neither the running frame nor starts a second one.
- R10: A read starts only on a command bit-0 write of 1 after the stored bit was 0. Writing 1 again without first writing 0 starts nothing.
- R11: Between frames MDC rests low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read-back |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read-back of the addressed register |
| mdc | output | 1 | Management serial clock |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data drive enable |
| mdio_i | input | 1 | Management data line sample |

## Verification
A launch request and the final falling MDC edge of a running frame can meet in the same cycle. The bench times a write-data strobe to land exactly on the edge that ends a frame. It expects that strobe to be ignored, with busy reading low a cycle later, and it expects a strobe one cycle after to start a new frame. The soft reset is also raised in the middle of a frame. The bench then checks that the line goes quiet and that launch writes stay without effect until the bit is cleared.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int unsigned OFF_CFG   = 0;
  localparam int unsigned OFF_CMD   = 1;
  localparam int unsigned OFF_ADDR  = 2;
  localparam int unsigned OFF_WDATA = 3;
  localparam int unsigned OFF_RDATA = 4;
  localparam int unsigned OFF_IND   = 5;

  // half of the MDC period, in system clocks, per encoded select
  function automatic int unsigned half_for_sel(logic [2:0] sel);
    case (sel)
      3'd0, 3'd1: return 2;
      3'd2:       return 3;
      3'd3:       return 4;
      3'd4:       return 5;
      3'd5:       return 7;
      3'd6:       return 10;
      default:    return 14;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
`timescale 1ns/1ps
module mdio_clkdiv #(
  parameter int unsigned CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  import mdio_pkg::*;

  logic [CNT_W-1:0] cnt_q, cnt_d, half;

  always_comb begin
    half  = CNT_W'(half_for_sel(sel));
    tick  = run && (cnt_q == half - 1'b1);
    cnt_d = (!run || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (run || cnt_q != '0)  cnt_q <= cnt_d;
  end

  // every half period is at least two clocks long
  assert_tick_spaced_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/mdio_frame.sv
`timescale 1ns/1ps
module mdio_frame #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AD_W   = 5,
  parameter int unsigned PRE_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic              is_rd,
  input  logic [AD_W-1:0]   phy_ad,
  input  logic [AD_W-1:0]   reg_ad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned FB     = PRE_W + 2 + 2 + 2 * AD_W + 2 + DATA_W;
  localparam int unsigned BIT_W  = $clog2(FB);
  localparam int unsigned TA_POS = FB - DATA_W - 2;

  logic              busy_q, busy_d, rd_q, rd_d, mdc_q, mdc_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [FB-1:0]     shf_q, shf_d;
  logic [DATA_W-1:0] cap_q, cap_d, rdata_q, rdata_d;

  always_comb begin
    busy_d  = busy_q;
    rd_d    = rd_q;
    mdc_d   = mdc_q;
    bit_d   = bit_q;
    shf_d   = shf_q;
    cap_d   = cap_q;
    rdata_d = rdata_q;
    if (abort) begin
      busy_d = 1'b0;
      mdc_d  = 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        rd_d   = is_rd;
        mdc_d  = 1'b0;
        bit_d  = '0;
        shf_d  = {{PRE_W{1'b1}}, 2'b01, (is_rd ? 2'b10 : 2'b01), phy_ad, reg_ad,
                  (is_rd ? 2'b11 : 2'b10), (is_rd ? {DATA_W{1'b1}} : wdata)};
      end
    end else if (tick) begin
      if (!mdc_q) begin
        mdc_d = 1'b1;
        if (rd_q) cap_d = {cap_q[DATA_W-2:0], mdio_i};
      end else begin
        mdc_d = 1'b0;
        if (bit_q == BIT_W'(FB - 1)) begin
          busy_d = 1'b0;
          if (rd_q) rdata_d = cap_q;
        end else begin
          bit_d = bit_q + 1'b1;
          shf_d = {shf_q[FB-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      mdc_q   <= 1'b0;
      bit_q   <= '0;
      shf_q   <= '0;
      cap_q   <= '0;
      rdata_q <= '0;
    end else begin
      busy_q  <= busy_d;
      rd_q    <= rd_d;
      mdc_q   <= mdc_d;
      bit_q   <= bit_d;
      shf_q   <= shf_d;
      cap_q   <= cap_d;
      rdata_q <= rdata_d;
    end
  end

  assign mdc     = mdc_q;
  assign mdio_o  = shf_q[FB-1];
  assign mdio_oe = busy_q && !(rd_q && (bit_q >= BIT_W'(TA_POS)));
  assign busy    = busy_q;
  assign rdata   = rdata_q;

  // a frame only ends normally after its last bit
  assert_full_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) && !$past(abort) |-> $past(bit_q) == BIT_W'(FB - 1));
  // between divider ticks the line and the clock hold, new requests included
  assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !tick && !abort |=> $stable(mdc_q) && $stable(shf_q) && $stable(bit_q));
  assert_mdc_low_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc_q);
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs #(
  parameter int unsigned DW     = 32,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AD_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_val,
  output logic              soft_rst,
  output logic [2:0]        clk_sel,
  output logic [AD_W-1:0]   phy_ad,
  output logic [AD_W-1:0]   reg_ad,
  output logic [DATA_W-1:0] frame_wd,
  output logic              start,
  output logic              start_rd
);
  import mdio_pkg::*;

  logic              cfg_rst_q;
  logic [4:0]        cfg_sel_q;
  logic              cmd_q;
  logic [AD_W-1:0]   phy_q, reg_q;
  logic [DATA_W-1:0] wd_q;
  logic              hit_cfg, hit_cmd, hit_addr, hit_wd, start_wr;

  always_comb begin
    hit_cfg  = we && (addr == 3'(OFF_CFG));
    hit_cmd  = we && (addr == 3'(OFF_CMD));
    hit_addr = we && (addr == 3'(OFF_ADDR));
    hit_wd   = we && (addr == 3'(OFF_WDATA));
    start_wr = hit_wd && !busy && !cfg_rst_q;
    start_rd = hit_cmd && wdata[0] && !cmd_q && !busy && !cfg_rst_q;
    start    = start_wr || start_rd;
    frame_wd = start_wr ? wdata[DATA_W-1:0] : wd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rst_q <= 1'b0;
      cfg_sel_q <= '0;
      cmd_q     <= 1'b0;
      phy_q     <= '0;
      reg_q     <= '0;
      wd_q      <= '0;
    end else begin
      if (hit_cfg) begin
        cfg_rst_q <= wdata[15];
        cfg_sel_q <= wdata[4:0];
      end
      if (hit_cmd)  cmd_q <= wdata[0];
      if (hit_addr) begin
        phy_q <= wdata[8 +: AD_W];
        reg_q <= wdata[0 +: AD_W];
      end
      if (hit_wd)   wd_q <= wdata[DATA_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      3'(OFF_CFG):   begin rdata[15] = cfg_rst_q; rdata[4:0] = cfg_sel_q; end
      3'(OFF_CMD):   rdata[0] = cmd_q;
      3'(OFF_ADDR):  begin rdata[8 +: AD_W] = phy_q; rdata[0 +: AD_W] = reg_q; end
      3'(OFF_WDATA): rdata[DATA_W-1:0] = wd_q;
      3'(OFF_RDATA): rdata[DATA_W-1:0] = rd_val;
      3'(OFF_IND):   rdata[0] = busy;
      default:       rdata = '0;
    endcase
  end

  assign soft_rst = cfg_rst_q;
  assign clk_sel  = cfg_sel_q[4:2];
  assign phy_ad   = phy_q;
  assign reg_ad   = reg_q;

  // the read result only moves while a frame runs
  assert_rdata_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rd_val));
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
  parameter int unsigned DW    = 32,
  parameter int unsigned CNT_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  localparam int unsigned DATA_W = 16;
  localparam int unsigned AD_W   = 5;

  logic [1:0]        sync_q;
  logic              rst_core_n;
  logic              soft_rst, start, start_rd, busy, tick;
  logic [2:0]        clk_sel;
  logic [AD_W-1:0]   phy_ad, reg_ad;
  logic [DATA_W-1:0] frame_wd, rd_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_core_n = sync_q[1];

  mdio_regs #(.DW(DW), .DATA_W(DATA_W), .AD_W(AD_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .rd_val(rd_val),
    .soft_rst(soft_rst), .clk_sel(clk_sel), .phy_ad(phy_ad), .reg_ad(reg_ad),
    .frame_wd(frame_wd), .start(start), .start_rd(start_rd));

  mdio_clkdiv #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_core_n), .run(busy && !soft_rst), .sel(clk_sel),
    .tick(tick));

  mdio_frame #(.DATA_W(DATA_W), .AD_W(AD_W), .PRE_W(32)) u_frame (
    .clk(clk), .rst_n(rst_core_n), .abort(soft_rst), .start(start),
    .is_rd(start_rd), .phy_ad(phy_ad), .reg_ad(reg_ad), .wdata(frame_wd),
    .tick(tick), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .busy(busy), .rdata(rd_val));
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int errors = 0;
  int nbits = 0;
  int hi_cnt = 0;
  int last_hi = 0;
  logic        prev_mdc = 1'b0;
  logic [63:0] cap_o, cap_oe;
  logic [15:0] phy_data = 16'h0;

  always #2 clk = ~clk;  // 250 MHz

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  function automatic int half_of(int sel);
    int t[8] = '{2, 2, 3, 4, 5, 7, 10, 14};
    return t[sel];
  endfunction

  function automatic logic phy_bit(int n);
    if (n >= 48 && n < 64) return phy_data[63-n];
    return 1'b1;
  endfunction

  function automatic logic [63:0] exp_frame(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
  endfunction

  // line monitor and PHY model, away from the active edge
  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      if (nbits < 64) begin
        cap_o[63-nbits]  = mdio_o;
        cap_oe[63-nbits] = mdio_oe;
      end
      nbits++;
    end
    if (!mdc && prev_mdc) begin
      last_hi = hi_cnt;
      mdio_i  = phy_bit(nbits);
    end
    hi_cnt   = mdc ? hi_cnt + 1 : 0;
    prev_mdc = mdc;
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(int a, output logic [31:0] v);
    reg_addr = 3'(a);
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] v;
    cyc = 0;
    rd_reg(5, v);
    while (v[0]) begin
      @(negedge clk);
      cyc++;
      rd_reg(5, v);
    end
  endtask

  task automatic do_frame(bit rd, logic [4:0] phy, logic [4:0] rg, logic [15:0] d, int sel);
    int h, cyc;
    logic [31:0] v;
    logic [63:0] ef, eoe;
    h = half_of(sel);
    wr_reg(0, 32'(sel << 2));
    wr_reg(2, {19'h0, phy, 3'b000, rg});
    phy_data = d; nbits = 0; mdio_i = 1'b1;
    if (rd) wr_reg(1, 32'h1); else wr_reg(3, {16'h0, d});
    wait_idle(cyc);
    chk(cyc == 128 * h, "R6 busy length", 64'(cyc), 64'(128 * h));
    chk(nbits == 64, "R6 bit count", 64'(nbits), 64'd64);
    chk(last_hi == h, "R7 mdc high width", 64'(last_hi), 64'(h));
    ef  = exp_frame(rd, phy, rg, d);
    eoe = rd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
    if (rd) begin
      chk(cap_o[63:18] == ef[63:18], "R4 read header", cap_o, ef);
      chk(cap_oe == eoe, "R4 release pattern", cap_oe, eoe);
      rd_reg(4, v);
      chk(v == {16'h0, d}, "R5 read data", 64'(v), 64'(d));
      wr_reg(1, 32'h0);
    end else begin
      chk(cap_o == ef, "R3 write frame", cap_o, ef);
      chk(cap_oe == eoe, "R3 drive enable", cap_oe, eoe);
    end
    chk(!mdc && !mdio_oe, "R11 idle line", {mdc, mdio_oe}, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc;
    logic [15:0] d0;
    void'($urandom(32'd24680));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; mdio_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    begin
      logic [31:0] acc;
      acc = '0;
      for (int a = 0; a < 6; a++) begin
        rd_reg(a, v);
        acc |= v;
      end
      chk(acc == 0, "R1 registers after reset", 64'(acc), 64'h0);
      chk(!mdc && !mdio_oe, "R1 line after reset", {mdc, mdio_oe}, 64'h0);
    end

    // R2 address field layout
    wr_reg(2, 32'hFFFF_FFFF);
    rd_reg(2, v);
    chk(v == 32'h1F1F, "R2 address read-back", 64'(v), 64'h1F1F);

    // R7 encoded select 0x1C
    wr_reg(0, 32'h1C);
    rd_reg(0, v);
    chk(v == 32'h1C, "R7 config read-back", 64'(v), 64'h1C);

    // directed frames at divide-by-28
    do_frame(1'b0, 5'h15, 5'h0A, 16'hA5C3, 7);
    do_frame(1'b1, 5'h01, 5'h02, 16'h8001, 7);

    // R10 read needs the command bit cleared first
    wr_reg(1, 32'h1);
    wait_idle(cyc);
    wr_reg(1, 32'h1);
    repeat (5) @(negedge clk);
    rd_reg(5, v);
    chk(v[0] == 1'b0, "R10 repeated set ignored", 64'(v[0]), 64'h0);
    wr_reg(1, 32'h0);
    wr_reg(1, 32'h1);
    rd_reg(5, v);
    chk(v[0] == 1'b1, "R10 rearmed read starts", 64'(v[0]), 64'h1);
    wait_idle(cyc);
    wr_reg(1, 32'h0);

    // R9 writes during a frame leave it untouched
    wr_reg(0, 32'(2 << 2));
    wr_reg(2, {19'h0, 5'h0C, 3'b000, 5'h13});
    nbits = 0;
    wr_reg(3, 32'h0000_5A0F);
    repeat (100) @(negedge clk);
    wr_reg(3, 32'h0000_A5F0);
    wr_reg(1, 32'h1);
    wait_idle(cyc);
    chk(cap_o == exp_frame(1'b0, 5'h0C, 5'h13, 16'h5A0F), "R9 frame unchanged",
        cap_o, exp_frame(1'b0, 5'h0C, 5'h13, 16'h5A0F));
    chk(nbits == 64, "R9 no second frame", 64'(nbits), 64'd64);
    wr_reg(1, 32'h0);

    // R9 launch landing on the closing edge, then one cycle later
    wr_reg(0, 32'h0);
    wr_reg(3, 32'h0000_1234);
    repeat (64 * 4 - 2) @(negedge clk);
    wr_reg(3, 32'h0000_4321);
    rd_reg(5, v);
    chk(v[0] == 1'b0, "R9 launch on closing edge ignored", 64'(v[0]), 64'h0);
    nbits = 0;
    wr_reg(3, 32'h0000_4321);
    rd_reg(5, v);
    chk(v[0] == 1'b1, "R9 launch after close starts", 64'(v[0]), 64'h1);
    wait_idle(cyc);
    chk(cyc == 256, "R6 busy length after collision", 64'(cyc), 64'd256);

    // R8 soft reset mid-frame
    wr_reg(0, 32'h1C);
    wr_reg(3, 32'h0000_FFFF);
    repeat (300) @(negedge clk);
    wr_reg(0, 32'h801C);
    @(negedge clk);
    rd_reg(5, v);
    chk(v[0] == 1'b0 && !mdc && !mdio_oe, "R8 abort quiets line",
        {v[0], mdc, mdio_oe}, 64'h0);
    wr_reg(3, 32'h0000_0001);
    repeat (3) @(negedge clk);
    rd_reg(5, v);
    chk(v[0] == 1'b0, "R8 launch ignored while held", 64'(v[0]), 64'h0);
    rd_reg(0, v);
    chk(v == 32'h801C, "R8 config read-back", 64'(v), 64'h801C);
    wr_reg(0, 32'h1C);

    // random frames with every select
    for (int i = 0; i < 10; i++) begin
      do_frame(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), i % 8);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule